// File: doc/BRIEF.md
# Packet Timestamp Unit

This block keeps a time-of-day clock made of a seconds count and a sub-second count of 10 ns ticks. On each start-of-packet strobe it captures the current time and presents it one cycle later with a valid flag. Successive captures are always strictly increasing, so every packet gets its own stamp even when packets arrive back to back.

The tick rate comes from a phase accumulator. A programmable increment, held as a fixed-point number of ticks per system clock, is added on every clock, and the carries advance the sub-second count. Software can set a new time of day, which takes effect on the next tick. Software can also rewrite the increment.

When discipline is enabled, a synchronised pulse-per-second input snaps the sub-second count to zero and moves the seconds count to the nearest whole second. The signed residual at that moment is recorded. The increment is then trimmed against it, so the local oscillator's drift is worked out over time. A small state machine supervises the pulse input. Its states are:
- OFF: discipline disabled. It goes to HUNT when enabled.
- HUNT: waiting for the first edge. It goes to GUARD on an edge, aligning the time but not trimming the increment.
- GUARD: edges are ignored as glitches. It goes to ARMED after the guard interval.
- ARMED: it goes to GUARD on an edge, aligning the time and trimming the increment.

Clearing the enable returns the machine to OFF from any state.

Top module: `pkt_ts_unit`

## Requirements
- R1: After reset the time reads 0 s / 0 ticks, `ts_valid` is 0, `pps_err` is 0 and the increment is 1.0 tick per clock (value `1 << FRAC_W`).
- R2: On every clock, `inc` (unsigned, FRAC_W fraction bits) is added to a FRAC_W-bit phase fraction. The integer carry of that sum (0 to 4) is added to `now_sub`. An `inc_wr` pulse replaces the increment from the following clock, and an increment of 0 freezes the time.
- R3: `now_sub` never reaches TICKS_PER_SEC. When a step would reach or pass it, the excess remains in `now_sub` and `now_sec` increments.
- R4: An `ld_stb` pulse stores `ld_sec`/`ld_sub`, with `ld_sub` clamped to TICKS_PER_SEC-1. The stored value replaces the time on the first later clock whose step is non-zero, and no earlier. That load takes priority over an alignment in the same cycle.
- R5: `pps_in` first sampled high at clock edge k makes `now_sub` read 0 after edge k+2, provided the edge is accepted. The seconds count is set to the nearest whole second: one more than the would-be seconds if the would-be sub-second value is at least half a second, and unchanged otherwise. The phase fraction is cleared.
- R6: On each accepted edge, `pps_err` (two's complement) takes the would-be sub-second value S if S < TICKS_PER_SEC/2, and S - TICKS_PER_SEC otherwise.
- R7: An edge accepted in ARMED subtracts `pps_err >>> ADJ_SHR` from the increment, clamped to its range.
- R8: After an accepted edge, further edges are ignored for GUARD_CYC clocks: the time, `pps_err` and the increment are untouched.
- R9: With `sync_en` low, `pps_in` has no effect. The first edge after re-enabling aligns the time and sets `pps_err` but leaves the increment unchanged.
- R10: A `sop` high at a clock edge produces `ts_valid` high after the next edge, carrying the time seen at the `sop` edge.
- R11: If that time is not greater than the previous stamp, the stamp is instead the previous stamp plus one tick, carrying into seconds at TICKS_PER_SEC-1. A completed load clears this history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Enables pulse-per-second discipline |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| inc_wr | input | 1 | Write strobe for the increment |
| inc_val | input | FRAC_W+2 | New increment, ticks per clock in fixed point |
| ld_stb | input | 1 | Time-load strobe |
| ld_sec | input | SEC_W | Seconds value to load |
| ld_sub | input | SUB_W | Sub-second value to load |
| sop | input | 1 | Start-of-packet strobe |
| ts_valid | output | 1 | Timestamp valid |
| ts_sec | output | SEC_W | Captured seconds |
| ts_sub | output | SUB_W | Captured sub-second ticks |
| now_sec | output | SEC_W | Current seconds |
| now_sub | output | SUB_W | Current sub-second ticks |
| pps_err | output | SUB_W+2 | Signed residual at the last accepted edge |

## Verification
Packet strobes are sent in bursts at increments of 1.0, 0.25 and 0. Across these runs stamps come from plain time, from a mix of real and bumped values, and from bumping alone; a final burst carries a bump across a second boundary. The pulse input is driven with intervals that are short against the nominal second. This yields a negative residual followed by a smaller one, which shows the trim took hold. A one-clock glitch inside the guard window checks that such edges are ignored. A pulse while disabled checks that it has no effect, and a re-enabled edge pair tells the untrimmed first edge from an armed one.

// File: rtl/pkt_ts_pkg.sv
package pkt_ts_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_HUNT  = 2'd1,
        PS_GUARD = 2'd2,
        PS_ARMED = 2'd3
    } pps_state_e;
endpackage

// File: rtl/pts_pps_sync.sv
module pts_pps_sync
    import pkt_ts_pkg::*;
#(
    parameter int GUARD_CYC = 50_000_000,
    localparam int GW = $clog2(GUARD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_in,
    input  logic sync_en,
    output logic accept,
    output logic first
);
    logic [2:0]  sh;
    logic        rise;
    logic [GW-1:0] cnt;
    pps_state_e  st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pps_in};
    end
    assign rise = sh[1] & ~sh[2];

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (accept || st != PS_GUARD) cnt <= '0;
        else                               cnt <= cnt + GW'(1);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_OFF:   if (sync_en) st_nx = PS_HUNT;
            PS_HUNT:  if (!sync_en) st_nx = PS_OFF;
                      else if (rise) st_nx = PS_GUARD;
            PS_GUARD: if (!sync_en) st_nx = PS_OFF;
                      else if (cnt == GW'(GUARD_CYC - 1)) st_nx = PS_ARMED;
            PS_ARMED: if (!sync_en) st_nx = PS_OFF;
                      else if (rise) st_nx = PS_GUARD;
        endcase
    end

    always_comb begin
        accept = rise && sync_en && (st == PS_HUNT || st == PS_ARMED);
        first  = (st == PS_HUNT);
    end

    a_r8_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_GUARD) |-> !accept);
    a_r9_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !accept);
endmodule

// File: rtl/pts_clock.sv
module pts_clock #(
    parameter int TPS     = 100_000_000,
    parameter int SEC_W   = 32,
    parameter int SUB_W   = 27,
    parameter int FRAC_W  = 24,
    parameter int ADJ_SHR = 3,
    localparam int IW   = FRAC_W + 2,
    localparam int RW   = SUB_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_wr,
    input  logic [IW-1:0]    inc_val,
    input  logic             ld_stb,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [SUB_W-1:0] ld_sub,
    input  logic             align,
    input  logic             drift_en,
    output logic [SEC_W-1:0] now_sec,
    output logic [SUB_W-1:0] now_sub,
    output logic [RW-1:0]    pps_err,
    output logic             load_done
);
    localparam int SW   = FRAC_W + 3;
    localparam int EW   = ((IW > RW) ? IW : RW) + 2;
    localparam int HALF = TPS / 2;

    logic [FRAC_W-1:0]    acc;
    logic [IW-1:0]        incr;
    logic [SEC_W-1:0]     sec, pend_sec, nxt_sec;
    logic [SUB_W-1:0]     sub, pend_sub, nxt_sub;
    logic                 pend, wrap, late, apply;
    logic signed [RW-1:0] err, resid;
    logic [SW-1:0]        sum;
    logic [2:0]           step;
    logic [SUB_W:0]       sub_add;
    logic signed [EW-1:0] inc_new;
    logic [IW-1:0]        inc_clamp;

    always_comb begin
        sum     = SW'(acc) + SW'(incr);
        step    = sum[SW-1:FRAC_W];
        sub_add = {1'b0, sub} + (SUB_W+1)'(step);
        wrap    = sub_add >= (SUB_W+1)'(TPS);
        nxt_sub = wrap ? SUB_W'(sub_add - (SUB_W+1)'(TPS)) : SUB_W'(sub_add);
        nxt_sec = sec + SEC_W'(wrap);
        late    = nxt_sub >= SUB_W'(HALF);
        resid   = late ? $signed(RW'(nxt_sub)) - $signed(RW'(TPS))
                       : $signed(RW'(nxt_sub));
        inc_new = EW'($signed({1'b0, incr})) - EW'(resid >>> ADJ_SHR);
        if (inc_new[EW-1])            inc_clamp = '0;
        else if (|inc_new[EW-2:IW])   inc_clamp = '1;
        else                          inc_clamp = inc_new[IW-1:0];
        apply   = pend && (step != 3'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            incr     <= IW'(1) << FRAC_W;
            sec      <= '0;
            sub      <= '0;
            pend     <= 1'b0;
            pend_sec <= '0;
            pend_sub <= '0;
            err      <= '0;
        end else begin
            if (apply) begin
                sec  <= pend_sec;
                sub  <= pend_sub;
                acc  <= sum[FRAC_W-1:0];
                pend <= 1'b0;
            end else if (align) begin
                sub <= '0;
                sec <= late ? nxt_sec + SEC_W'(1) : nxt_sec;
                acc <= '0;
                err <= resid;
                if (drift_en) incr <= inc_clamp;
            end else begin
                sub <= nxt_sub;
                sec <= nxt_sec;
                acc <= sum[FRAC_W-1:0];
            end
            if (ld_stb) begin
                pend     <= 1'b1;
                pend_sec <= ld_sec;
                pend_sub <= ({1'b0, ld_sub} >= (SUB_W+1)'(TPS)) ? SUB_W'(TPS - 1) : ld_sub;
            end
            if (inc_wr) incr <= inc_val;
        end
    end

    assign now_sec   = sec;
    assign now_sub   = sub;
    assign pps_err   = err;
    assign load_done = apply;

    a_r3_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, sub} < (SUB_W+1)'(TPS));
    a_r4_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (sec == $past(pend_sec)) && (sub == $past(pend_sub)));
    a_r5_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (align && !apply) |=> (sub == '0));
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd0 && !align && !apply) |=> $stable(sub) && $stable(sec));
endmodule

// File: rtl/pts_capture.sv
module pts_capture #(
    parameter int TPS   = 100_000_000,
    parameter int SEC_W = 32,
    parameter int SUB_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sop,
    input  logic             clr,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [SUB_W-1:0] cur_sub,
    output logic             ts_valid,
    output logic [SEC_W-1:0] ts_sec,
    output logic [SUB_W-1:0] ts_sub
);
    logic             hist_v, cur_le;
    logic [SEC_W-1:0] bump_sec, pick_sec;
    logic [SUB_W-1:0] bump_sub, pick_sub;

    always_comb begin
        cur_le = hist_v && ({cur_sec, cur_sub} <= {ts_sec, ts_sub});
        if (ts_sub == SUB_W'(TPS - 1)) begin
            bump_sec = ts_sec + SEC_W'(1);
            bump_sub = '0;
        end else begin
            bump_sec = ts_sec;
            bump_sub = ts_sub + SUB_W'(1);
        end
        pick_sec = cur_le ? bump_sec : cur_sec;
        pick_sub = cur_le ? bump_sub : cur_sub;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_valid <= 1'b0;
            ts_sec   <= '0;
            ts_sub   <= '0;
            hist_v   <= 1'b0;
        end else begin
            ts_valid <= sop;
            if (sop) begin
                ts_sec <= pick_sec;
                ts_sub <= pick_sub;
                hist_v <= 1'b1;
            end
            if (clr) hist_v <= 1'b0;
        end
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> ts_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !sop |=> !ts_valid);
    a_r11_increasing: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && hist_v) |=> ({ts_sec, ts_sub} > $past({ts_sec, ts_sub})));
endmodule

// File: rtl/pkt_ts_unit.sv
module pkt_ts_unit #(
    parameter int TPS       = 100_000_000,
    parameter int SEC_W     = 32,
    parameter int FRAC_W    = 24,
    parameter int ADJ_SHR   = 3,
    parameter int GUARD_CYC = 50_000_000,
    localparam int SUB_W    = $clog2(TPS),
    localparam int IW       = FRAC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic             pps_in,
    input  logic             inc_wr,
    input  logic [IW-1:0]    inc_val,
    input  logic             ld_stb,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [SUB_W-1:0] ld_sub,
    input  logic             sop,
    output logic             ts_valid,
    output logic [SEC_W-1:0] ts_sec,
    output logic [SUB_W-1:0] ts_sub,
    output logic [SEC_W-1:0] now_sec,
    output logic [SUB_W-1:0] now_sub,
    output logic [SUB_W+1:0] pps_err
);
    logic accept, first, load_done;

    pts_pps_sync #(.GUARD_CYC(GUARD_CYC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .sync_en(sync_en),
        .accept(accept), .first(first)
    );

    pts_clock #(
        .TPS(TPS), .SEC_W(SEC_W), .SUB_W(SUB_W), .FRAC_W(FRAC_W), .ADJ_SHR(ADJ_SHR)
    ) u_clock (
        .clk(clk), .rst_n(rst_n), .inc_wr(inc_wr), .inc_val(inc_val),
        .ld_stb(ld_stb), .ld_sec(ld_sec), .ld_sub(ld_sub),
        .align(accept), .drift_en(!first),
        .now_sec(now_sec), .now_sub(now_sub), .pps_err(pps_err),
        .load_done(load_done)
    );

    pts_capture #(.TPS(TPS), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sop(sop), .clr(load_done),
        .cur_sec(now_sec), .cur_sub(now_sub),
        .ts_valid(ts_valid), .ts_sec(ts_sec), .ts_sub(ts_sub)
    );
endmodule

// File: tb/sim_pkt_ts_unit.sv
module sim_pkt_ts_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TPS = 200;

    logic        clk = 1'b0, rst_n = 1'b0, sync_en = 1'b0, pps_in = 1'b0;
    logic        inc_wr = 1'b0, ld_stb = 1'b0, sop = 1'b0;
    logic [9:0]  inc_val = '0;
    logic [31:0] ld_sec = '0;
    logic [7:0]  ld_sub = '0;
    logic        ts_valid;
    logic [31:0] ts_sec, now_sec;
    logic [7:0]  ts_sub, now_sub;
    logic [9:0]  pps_err;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] s; logic [7:0] u; bit bumped; } exp_t;
    exp_t q[$];
    bit          hv = 1'b0;
    logic [31:0] ls = '0;
    logic [7:0]  lu = '0;

    pkt_ts_unit #(.TPS(TPS), .SEC_W(32), .FRAC_W(8), .ADJ_SHR(0), .GUARD_CYC(100)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .pps_in(pps_in),
        .inc_wr(inc_wr), .inc_val(inc_val), .ld_stb(ld_stb), .ld_sec(ld_sec),
        .ld_sub(ld_sub), .sop(sop), .ts_valid(ts_valid), .ts_sec(ts_sec),
        .ts_sub(ts_sub), .now_sec(now_sec), .now_sub(now_sub), .pps_err(pps_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nxt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_inc(input logic [9:0] v);
        inc_val = v; inc_wr = 1'b1;
        @(negedge clk);
        inc_wr = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [7:0] u);
        ld_sec = s; ld_sub = u; ld_stb = 1'b1; hv = 1'b0;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic pulse(input int hi);
        pps_in = 1'b1;
        nxt(hi);
        pps_in = 1'b0;
    endtask

    task automatic sop_burst(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            if (hv && {now_sec, now_sub} <= {ls, lu}) begin
                e.bumped = 1'b1;
                if (lu == 8'(TPS - 1)) begin e.s = ls + 1; e.u = '0; end
                else begin e.s = ls; e.u = lu + 1; end
            end else begin
                e.bumped = 1'b0; e.s = now_sec; e.u = now_sub;
            end
            ls = e.s; lu = e.u; hv = 1'b1;
            q.push_back(e);
            sop = 1'b1;
            @(negedge clk);
        end
        sop = 1'b0;
        nxt(2);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ts_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({ts_sec, ts_sub} == {e.s, e.u}, e.bumped ? "R11 bumped stamp" : "R10 stamp",
                        {ts_sec, ts_sub}, {e.s, e.u});
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  s0;
        logic [31:0] sb;
        nxt(3);
        // R1 reset state
        chk(now_sec == 0 && now_sub == 0, "R1 time", {now_sec, now_sub}, 0);
        chk(ts_valid == 0, "R1 ts_valid", ts_valid, 0);
        chk(pps_err == 0, "R1 pps_err", pps_err, 0);
        rst_n = 1'b1;
        // R2 nominal rate
        s0 = now_sub; nxt(10);
        chk(now_sub == s0 + 10, "R2 rate 1.0", now_sub, s0 + 10);
        wr_inc(10'd64);
        s0 = now_sub; nxt(8);
        chk(now_sub == s0 + 2, "R2 rate 0.25", now_sub, s0 + 2);
        wr_inc(10'd640);
        s0 = now_sub; nxt(4);
        chk(now_sub == s0 + 10, "R2 rate 2.5", now_sub, s0 + 10);
        // R4 load waits for a tick
        wr_inc(10'd0);
        s0 = now_sub; sb = now_sec;
        load(32'd7, 8'd198);
        nxt(3);
        chk({now_sec, now_sub} == {sb, s0}, "R4 load held while frozen", {now_sec, now_sub}, {sb, s0});
        wr_inc(10'd256);
        chk({now_sec, now_sub} == {sb, s0}, "R4 load not before tick", {now_sec, now_sub}, {sb, s0});
        nxt(1);
        chk({now_sec, now_sub} == {32'd7, 8'd198}, "R4 load applied", {now_sec, now_sub}, {32'd7, 8'd198});
        nxt(1);
        chk(now_sub == 8'd199, "R3 pre-wrap", now_sub, 199);
        nxt(1);
        chk({now_sec, now_sub} == {32'd8, 8'd0}, "R3 wrap", {now_sec, now_sub}, {32'd8, 8'd0});
        // R10/R11 capture bursts
        sop_burst(6);
        wr_inc(10'd64);
        sop_burst(8);
        wr_inc(10'd0);
        sop_burst(4);
        wr_inc(10'd256);
        load(32'd20, 8'd196);
        wr_inc(10'd0);
        chk({now_sec, now_sub} == {32'd20, 8'd196}, "R4 load for wrap test", {now_sec, now_sub}, {32'd20, 8'd196});
        sop_burst(5);
        // PPS discipline
        wr_inc(10'd256);
        sync_en = 1'b1;
        nxt(3);
        pulse(3);
        chk(now_sub == 0, "R5 first edge zeroes", now_sub, 0);
        nxt(187);
        sb = now_sec;
        pulse(3);
        chk($signed(pps_err) == -10, "R6 negative residual", $signed(pps_err), -10);
        chk(now_sub == 0 && now_sec == sb + 1, "R5 round up second", {now_sec, now_sub}, {sb + 32'd1, 8'd0});
        nxt(27);
        pulse(1);
        nxt(7);
        chk(now_sub == 8'd36, "R8 glitch ignored time", now_sub, 36);
        chk($signed(pps_err) == -10, "R8 glitch ignored err", $signed(pps_err), -10);
        nxt(152);
        sb = now_sec;
        pulse(3);
        chk($signed(pps_err) == -3, "R7 trimmed residual", $signed(pps_err), -3);
        chk(now_sec == sb + 1, "R5 second after trim", now_sec, sb + 1);
        nxt(10);
        sync_en = 1'b0;
        nxt(40);
        pulse(3);
        nxt(7);
        chk(now_sub == 8'd63, "R9 disabled time", now_sub, 63);
        chk($signed(pps_err) == -3, "R9 disabled err", $signed(pps_err), -3);
        nxt(10);
        sync_en = 1'b1;
        nxt(10);
        sb = now_sec;
        pulse(3);
        chk($signed(pps_err) == 87, "R6 positive residual", $signed(pps_err), 87);
        chk(now_sub == 0 && now_sec == sb, "R5 round down second", {now_sec, now_sub}, {sb, 8'd0});
        nxt(187);
        pulse(3);
        chk($signed(pps_err) == -1, "R9 hunt edge no trim", $signed(pps_err), -1);
        nxt(3);
        chk(q.size() == 0, "R10 all stamps seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule